// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the word-select (frame) clock of an audio serial port, plus a one-cycle launch strobe for a serializer running in the same clock domain. The input clock `clk` runs at twice the audio master-clock rate. A bit-clock ratio R (master clocks per bit clock) therefore gives a bit clock with a period of 2·R `clk` cycles: R cycles low, then R cycles high. A ratio of 1 needs no special case, and neither does the one-and-a-half scaling.

The ratio comes from one of two divider schemes. The legacy scheme holds a log2 code that selects a power-of-two ratio. The wide scheme holds the ratio minus one. In the wide scheme the ratio is raised by half when the stream is 16-bit, 8-channel. The frame clock spans a programmable number of bit clocks. Either clock can be inverted.

The sequencer has three states. In IDLE all outputs sit at their inactive levels and the counters are zero. LOW is the first half of a bit period and HIGH is the second half. The transitions are:

- START: IDLE to LOW, when the block is enabled with a legal configuration.
- RISE: LOW to HIGH, after R cycles.
- FALL: HIGH to LOW, after R cycles. This also advances the bit-in-frame counter.
- STOP: any state to IDLE, when the enable drops or the configuration is illegal.

Top module: `aclk_gen`

## Requirements
- R1: While `rst_n` is low, `bclk`, `fclk` and `bclk_stb` are 0. After reset, while `div_en` is 0, `bclk` equals `bclk_inv`, `fclk` equals `fclk_inv` and `bclk_stb` is 0, starting one clock after `div_en` is sampled low.
- R2: With `div_sel_wide`=0, the ratio is R = 2^`legacy_log2` (codes 0..3 give 1, 2, 4, 8). The bit clock is low for R cycles, then high for R cycles.
- R3: With `div_sel_wide`=1 and `legacy_log2`=0, the ratio is R = `wide_m1`+1 (1..64). This holds unless both `fmt_16b` and `fmt_8ch` are 1.
- R4: With `div_sel_wide`=1, `fmt_16b`=1 and `fmt_8ch`=1, the ratio is R = 1.5·(`wide_m1`+1), provided `wide_m1`+1 is even. Either format flag alone leaves the ratio unscaled.
- R5: The block stays in IDLE with the outputs at their R1 levels while enabled in either of two cases: `div_sel_wide`=1 with a nonzero `legacy_log2`, or a scaled wide setting whose nominal ratio `wide_m1`+1 is odd.
- R6: With `div_sel_wide`=0, the values of `wide_m1`, `fmt_16b` and `fmt_8ch` have no effect on the outputs.
- R7: In the first clock after `div_en` is sampled high with a legal configuration, a full LOW phase begins from zeroed counters. No shortened phase occurs.
- R8: `bclk_stb` is 1 for exactly the first cycle of every LOW phase, including the first one after enable, and is 0 otherwise.
- R9: A frame is F = `frame_m1`+1 bit periods. The uninverted frame clock is 0 during bit periods 0 .. floor(F/2)-1 and 1 for the rest of the frame. It changes only at the start of a bit period.
- R10: `bclk_inv` inverts `bclk` and `fclk_inv` inverts `fclk`, in both active and idle states. `bclk_stb` is not affected by either bit.
- R11: Dropping `div_en` in the middle of a phase returns every output to idle one clock later. A later enable restarts from bit period 0, phase LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the master-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_en | input | 1 | Divider enable; 0 holds outputs idle |
| div_sel_wide | input | 1 | 1 selects the wide divider, 0 the legacy divider |
| legacy_log2 | input | LEG_W (2) | log2 of the legacy ratio |
| wide_m1 | input | WIDE_W (6) | Wide ratio minus one |
| fmt_16b | input | 1 | Stream uses 16-bit samples |
| fmt_8ch | input | 1 | Stream has 8 channels |
| frame_m1 | input | FRAME_W (12) | Bit clocks per frame minus one |
| bclk_inv | input | 1 | Invert the bit clock |
| fclk_inv | input | 1 | Invert the frame clock |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame (word-select) clock |
| bclk_stb | output | 1 | One-cycle pulse at each bit-period start |

## Verification
Each legacy code is run, and so is each end of the wide range (ratio 1 and ratio 64). Together these show that the two encodings decode differently: one as a shift, the other as an offset. Scaled runs use nominal ratios 2 and 64. A run with only the 16-bit flag set shows that the one-and-a-half factor needs both format flags. Odd nominal ratios and a nonzero legacy code in wide mode must leave the outputs idle, which separates the legal settings from the rejected ones. Frames of 1, 5 and 64 bit clocks, the inversion bits, a mid-phase disable and a seeded random sweep of all fields complete the set. Every active cycle is compared against a waveform computed from the ratio and the frame length.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } aclk_state_e;
endpackage

// File: rtl/aclk_ratio.sv
// Decodes the divider fields into a half-period length (in clk cycles)
// and flags settings that must keep the generator idle.
module aclk_ratio #(
    parameter int LEG_W  = 2,
    parameter int WIDE_W = 6,
    parameter int HALF_W = 8
) (
    input  logic              sel_wide,
    input  logic [LEG_W-1:0]  legacy_log2,
    input  logic [WIDE_W-1:0] wide_m1,
    input  logic              fmt_16b,
    input  logic              fmt_8ch,
    output logic [HALF_W-1:0] half_len,
    output logic              cfg_ok
);
    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    logic [HALF_W-1:0] nominal;
    logic              scale_up;

    assign nominal  = HALF_W'(wide_m1) + ONE;
    assign scale_up = fmt_16b && fmt_8ch;

    always_comb begin
        half_len = ONE;
        cfg_ok   = 1'b1;
        if (sel_wide) begin
            if (legacy_log2 != '0) begin
                cfg_ok = 1'b0;
            end
            if (scale_up) begin
                if (nominal[0]) begin
                    cfg_ok = 1'b0;
                end
                half_len = nominal + (nominal >> 1);
            end else begin
                half_len = nominal;
            end
        end else begin
            half_len = ONE << legacy_log2;
        end
    end
endmodule

// File: rtl/aclk_seq.sv
// Three-state sequencer: IDLE, LOW (first half of a bit), HIGH (second half).
module aclk_seq
    import aclk_pkg::*;
#(
    parameter int HALF_W  = 8,
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [HALF_W-1:0]  half_len,
    input  logic [FRAME_W-1:0] frame_m1,
    input  logic               bclk_inv,
    input  logic               fclk_inv,
    output logic               bclk,
    output logic               fclk,
    output logic               bclk_stb,
    output logic               active
);
    localparam logic [HALF_W-1:0]  H_ONE = HALF_W'(1);
    localparam logic [FRAME_W-1:0] F_ONE = FRAME_W'(1);

    aclk_state_e        st_q, st_nx;
    logic [HALF_W-1:0]  hc_q, hc_nx;
    logic [FRAME_W-1:0] bc_q, bc_nx;
    logic               phase_end;
    logic [FRAME_W:0]   frame_mid;

    assign phase_end = (hc_q == half_len - H_ONE);
    assign frame_mid = ({1'b0, frame_m1} + {{FRAME_W{1'b0}}, 1'b1}) >> 1;

    // Next-state logic: START, RISE, FALL, STOP
    always_comb begin
        st_nx = st_q;
        hc_nx = hc_q;
        bc_nx = bc_q;
        if (!run) begin
            st_nx = S_IDLE;                       // STOP
            hc_nx = '0;
            bc_nx = '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin                     // START
                    st_nx = S_LOW;
                    hc_nx = '0;
                    bc_nx = '0;
                end
                S_LOW: begin
                    if (phase_end) begin          // RISE
                        st_nx = S_HIGH;
                        hc_nx = '0;
                    end else begin
                        hc_nx = hc_q + H_ONE;
                    end
                end
                S_HIGH: begin
                    if (phase_end) begin          // FALL
                        st_nx = S_LOW;
                        hc_nx = '0;
                        bc_nx = (bc_q == frame_m1) ? '0 : bc_q + F_ONE;
                    end else begin
                        hc_nx = hc_q + H_ONE;
                    end
                end
                default: begin
                    st_nx = S_IDLE;
                    hc_nx = '0;
                    bc_nx = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
            hc_q <= '0;
            bc_q <= '0;
        end else begin
            st_q <= st_nx;
            hc_q <= hc_nx;
            bc_q <= bc_nx;
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk     <= 1'b0;
            fclk     <= 1'b0;
            bclk_stb <= 1'b0;
        end else begin
            bclk     <= (st_nx == S_HIGH) ^ bclk_inv;
            fclk     <= ((st_nx != S_IDLE) && ({1'b0, bc_nx} >= frame_mid)) ^ fclk_inv;
            bclk_stb <= (st_nx == S_LOW) && (hc_nx == '0);
        end
    end

    assign active = (st_q != S_IDLE);
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen #(
    parameter int LEG_W   = 2,
    parameter int WIDE_W  = 6,
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               div_en,
    input  logic               div_sel_wide,
    input  logic [LEG_W-1:0]   legacy_log2,
    input  logic [WIDE_W-1:0]  wide_m1,
    input  logic               fmt_16b,
    input  logic               fmt_8ch,
    input  logic [FRAME_W-1:0] frame_m1,
    input  logic               bclk_inv,
    input  logic               fclk_inv,
    output logic               bclk,
    output logic               fclk,
    output logic               bclk_stb
);
    localparam int HALF_W = ((WIDE_W + 1) > (2 ** LEG_W)) ? (WIDE_W + 1) : (2 ** LEG_W);

    logic [HALF_W-1:0] half_len;
    logic              cfg_ok;
    logic              seq_active;

    aclk_ratio #(
        .LEG_W (LEG_W),
        .WIDE_W(WIDE_W),
        .HALF_W(HALF_W)
    ) u_ratio (
        .sel_wide   (div_sel_wide),
        .legacy_log2(legacy_log2),
        .wide_m1    (wide_m1),
        .fmt_16b    (fmt_16b),
        .fmt_8ch    (fmt_8ch),
        .half_len   (half_len),
        .cfg_ok     (cfg_ok)
    );

    aclk_seq #(
        .HALF_W (HALF_W),
        .FRAME_W(FRAME_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (div_en && cfg_ok),
        .half_len(half_len),
        .frame_m1(frame_m1),
        .bclk_inv(bclk_inv),
        .fclk_inv(fclk_inv),
        .bclk    (bclk),
        .fclk    (fclk),
        .bclk_stb(bclk_stb),
        .active  (seq_active)
    );
endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk #(
    parameter int LEG_W   = 2,
    parameter int WIDE_W  = 6,
    parameter int FRAME_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               div_en,
    input logic               div_sel_wide,
    input logic [LEG_W-1:0]   legacy_log2,
    input logic [WIDE_W-1:0]  wide_m1,
    input logic               fmt_16b,
    input logic               fmt_8ch,
    input logic [FRAME_W-1:0] frame_m1,
    input logic               bclk_inv,
    input logic               fclk_inv,
    input logic               bclk,
    input logic               fclk,
    input logic               bclk_stb,
    input logic               seq_active
);
    logic illegal;
    assign illegal = div_sel_wide &&
                     ((legacy_log2 != '0) || (fmt_16b && fmt_8ch && !wide_m1[0]));

    // R1
    a_r1_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |=> (!bclk_stb && bclk == $past(bclk_inv) && fclk == $past(fclk_inv)));

    // R5
    a_r5_reject_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && illegal) |=> (!bclk_stb && bclk == $past(bclk_inv) && fclk == $past(fclk_inv)));

    // R8: strobe lasts one cycle
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stb |=> !bclk_stb);

    // R8: strobe falls in a LOW phase
    a_r8_strobe_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stb |-> (bclk == $past(bclk_inv)));

    // R9
    a_r9_frame_on_bit_start: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_active && $past(seq_active) && !bclk_stb &&
         $past(fclk_inv) == $past(fclk_inv, 2) &&
         $past(frame_m1) == $past(frame_m1, 2)) |-> $stable(fclk));
endmodule

bind aclk_gen aclk_gen_chk #(
    .LEG_W  (LEG_W),
    .WIDE_W (WIDE_W),
    .FRAME_W(FRAME_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_en      (div_en),
    .div_sel_wide(div_sel_wide),
    .legacy_log2 (legacy_log2),
    .wide_m1     (wide_m1),
    .fmt_16b     (fmt_16b),
    .fmt_8ch     (fmt_8ch),
    .frame_m1    (frame_m1),
    .bclk_inv    (bclk_inv),
    .fclk_inv    (fclk_inv),
    .bclk        (bclk),
    .fclk        (fclk),
    .bclk_stb    (bclk_stb),
    .seq_active  (seq_active)
);

// File: tb/aclk_gen_bench.sv
`timescale 1ns/1ps
module aclk_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_en = 1'b0;
    logic        div_sel_wide = 1'b0;
    logic [1:0]  legacy_log2 = '0;
    logic [5:0]  wide_m1 = '0;
    logic        fmt_16b = 1'b0;
    logic        fmt_8ch = 1'b0;
    logic [11:0] frame_m1 = 12'd63;
    logic        bclk_inv = 1'b0;
    logic        fclk_inv = 1'b0;
    logic        bclk, fclk, bclk_stb;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    aclk_gen u_aclk_gen (
        .clk(clk), .rst_n(rst_n), .div_en(div_en), .div_sel_wide(div_sel_wide),
        .legacy_log2(legacy_log2), .wide_m1(wide_m1), .fmt_16b(fmt_16b),
        .fmt_8ch(fmt_8ch), .frame_m1(frame_m1), .bclk_inv(bclk_inv),
        .fclk_inv(fclk_inv), .bclk(bclk), .fclk(fclk), .bclk_stb(bclk_stb)
    );

    // Half-period in clk cycles from the requirements; 0 means rejected.
    function automatic int exp_half(input bit sel, input int lg, input int m1,
                                    input bit f16, input bit c8);
        int n;
        if (!sel) return 1 << lg;
        if (lg != 0) return 0;
        n = m1 + 1;
        if (f16 && c8) begin
            if (n % 2 != 0) return 0;
            return n + n / 2;
        end
        return n;
    endfunction

    task automatic check3(input string req, input bit eb, input bit ef, input bit es);
        n_checks++;
        if (bclk !== eb || fclk !== ef || bclk_stb !== es) begin
            n_fails++;
            $display("FAIL %s: bclk/fclk/stb actual %b%b%b expected %b%b%b at %0t",
                     req, bclk, fclk, bclk_stb, eb, ef, es, $time);
        end
    endtask

    task automatic run_case(input bit sel, input int lg, input int m1, input bit f16,
                            input bit c8, input int fm1, input bit bi, input bit fi,
                            input int cap, input string req);
        int h, f, n;
        @(negedge clk);
        div_en = 1'b0;
        div_sel_wide = sel; legacy_log2 = 2'(lg); wide_m1 = 6'(m1);
        fmt_16b = f16; fmt_8ch = c8; frame_m1 = 12'(fm1);
        bclk_inv = bi; fclk_inv = fi;
        @(negedge clk);
        @(negedge clk);
        check3({req, " idle before enable (R1 R10)"}, bi, fi, 1'b0);
        h = exp_half(sel, lg, m1, f16, c8);
        f = fm1 + 1;
        div_en = 1'b1;
        if (h == 0) begin
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                check3({req, " rejected setting stays idle (R5)"}, bi, fi, 1'b0);
            end
        end else begin
            n = 4 * h * f + 4;
            if (n > cap) n = cap;
            for (int t = 0; t < n; t++) begin
                int ph, bidx;
                @(negedge clk);
                ph   = t % (2 * h);
                bidx = (t / (2 * h)) % f;
                check3({req, " waveform (R7 R8 R9)"},
                       (ph >= h) ^ bi, (bidx >= f / 2) ^ fi, ph == 0);
            end
        end
        div_en = 1'b0;
        @(negedge clk);
        check3({req, " idle after disable (R11)"}, bi, fi, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check3("R1 reset state", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int lg = 0; lg < 4; lg++)
            run_case(1'b0, lg, 0, 1'b0, 1'b0, 63, 1'b0, 1'b0, 6000, "R2 legacy");
        run_case(1'b0, 2, 17, 1'b1, 1'b1, 7, 1'b0, 1'b0, 6000, "R6 legacy ignores wide");
        run_case(1'b1, 0, 0, 1'b0, 1'b0, 63, 1'b0, 1'b0, 6000, "R3 wide ratio 1");
        run_case(1'b1, 0, 63, 1'b0, 1'b0, 3, 1'b0, 1'b0, 6000, "R3 wide ratio 64");
        run_case(1'b1, 0, 1, 1'b1, 1'b1, 9, 1'b0, 1'b0, 6000, "R4 scaled ratio 2");
        run_case(1'b1, 0, 63, 1'b1, 1'b1, 63, 1'b0, 1'b0, 6000, "R4 scaled ratio 64");
        run_case(1'b1, 0, 2, 1'b1, 1'b0, 5, 1'b0, 1'b0, 6000, "R4 one flag only");
        run_case(1'b1, 0, 2, 1'b1, 1'b1, 5, 1'b0, 1'b0, 6000, "R5 odd nominal");
        run_case(1'b1, 1, 3, 1'b0, 1'b0, 5, 1'b0, 1'b0, 6000, "R5 legacy field nonzero");
        run_case(1'b0, 1, 0, 1'b0, 1'b0, 4, 1'b1, 1'b0, 6000, "R10 bclk inverted R9 odd frame");
        run_case(1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b1, 6000, "R10 fclk inverted R9 one-bit frame");
        run_case(1'b1, 0, 4, 1'b0, 1'b0, 7, 1'b1, 1'b1, 7, "R11 mid-phase stop");
        run_case(1'b1, 0, 4, 1'b0, 1'b0, 7, 1'b1, 1'b1, 6000, "R11 fresh restart");

        for (int i = 0; i < 10; i++) begin
            run_case(1'($urandom), int'($urandom % 4), int'($urandom % 64),
                     1'($urandom), 1'($urandom), int'($urandom % 16),
                     1'($urandom), 1'($urandom), 3000, "R3 R4 R5 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule